// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall time as an unsigned 32-bit count of seconds. An external one-pulse-per-second strobe advances the count while a run bit is set. Software reaches the block through a byte-wide register port that has single-cycle read and write strobes. Reads return data one cycle after the strobe.

Software sets the time through a staging register. The three upper bytes are written first, and the write of the least significant byte commits all 32 bits in one step. A partly written value is therefore never counted. The alarm is a 32-bit compare value with an enable bit and a sticky status bit. When a tick moves the count onto the compare value, the status bit sets and the enable bit clears itself, so each arming gives at most one event. The interrupt output follows the status bit, so it rises exactly once per event.

Register map (4-bit byte address). Multi-byte values are little-endian, with lane 0 as the least significant byte:
- 0x0: run control.
- 0x1: alarm enable.
- 0x2: alarm status.
- 0x4 to 0x7: time staging window.
- 0x8 to 0xB: live count.
- 0xC to 0xF: alarm compare value.

Top module: `rtc_seconds`

## Requirements
- R1: After reset, the count, staging value, alarm value, run bit, alarm enable and alarm status are all zero. Every register address reads 0x00 and `alarm_irq` is low.
- R2: While bit 7 of address 0x0 is set, each cycle with `tick_i` high adds one to the count. While that bit is clear, the count holds through ticks.
- R3: The count wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R4: Writes to 0x5, 0x6 and 0x7 change only the staging bytes 1 to 3 and never the count. A write to 0x4 loads {staging bytes 3..1, written byte} into the count at that same clock edge. If a tick falls in the same cycle as that write, the load takes effect and the tick is dropped.
- R5: A read of 0x8+n returns byte n of the live count, and a read of 0x4+n returns staging byte n. The value appears on `rdata` in the cycle after `rd_en` and reflects the state before that edge.
- R6: Addresses 0xC to 0xF write and read back the alarm compare bytes 0 to 3.
- R7: With the alarm enabled, a tick that advances the count to the compare value sets the status and clears the enable at the same edge. `alarm_irq` equals the status bit, so it rises at that edge.
- R8: Writing 0x2 with bit 0 at 0 clears the status, and writing it with bit 0 at 1 leaves the status unchanged. If a firing and a clearing write fall in the same cycle, the status stays set.
- R9: The alarm does not fire while disabled. A count loaded through 0x4 that equals the compare value does not fire the alarm.
- R10: The alarm enable sits at bit ALM_EN_BIT of 0x1 (default 1). The other bits of 0x1 read 0, and writes to them are ignored. Address 0x0 reads {run, 7'b0}, address 0x2 reads {7'b0, status}, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| alarm_irq | output | 1 | Alarm status; its rising edge signals an alarm event |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a firing alarm and a software write that clears the status. The second is a one-second tick and the commit write to the low staging byte. The bench provokes each pair directly by driving the write strobe in the very cycle that `tick_i` is high. It places the count one second before the compare value for the first case and at an arbitrary value for the second. It judges the first case by `alarm_irq` staying high, and the second by the read-back count equalling the loaded value with no increment added. Random mixes of ticks and writes revisit both collisions against a reference model kept in the bench.

// File: rtl/rtc_seconds.sv
`timescale 1ns/1ps
module rtc_seconds #(
  parameter int unsigned ALM_EN_BIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_irq
);
  localparam logic [3:0] A_RUN  = 4'h0;
  localparam logic [3:0] A_AEN  = 4'h1;
  localparam logic [3:0] A_ASTS = 4'h2;
  localparam logic [1:0] W_REGS  = 2'd0;
  localparam logic [1:0] W_STAGE = 2'd1;
  localparam logic [1:0] W_COUNT = 2'd2;
  localparam logic [1:0] W_ALARM = 2'd3;

  logic [31:0] cnt_q, stage_q, alm_q, cnt_inc;
  logic        run_q, alm_en_q, alm_sts_q;
  logic [1:0]  win, lane;
  logic        load, step, fire, sts_clr;

  assign win     = addr[3:2];
  assign lane    = addr[1:0];
  assign cnt_inc = cnt_q + 32'd1;
  assign load    = wr_en && (win == W_STAGE) && (lane == 2'd0);
  assign step    = tick_i && run_q && !load;
  assign fire    = step && alm_en_q && (cnt_inc == alm_q);
  assign sts_clr = wr_en && (addr == A_ASTS) && !wdata[0];
  assign alarm_irq = alm_sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= {stage_q[31:8], wdata};
    else if (step) cnt_q <= cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      alm_q   <= '0;
    end else if (wr_en) begin
      if (win == W_STAGE) stage_q[lane*8 +: 8] <= wdata;
      if (win == W_ALARM) alm_q[lane*8 +: 8]   <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      alm_en_q  <= 1'b0;
      alm_sts_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_RUN) run_q <= wdata[7];
      if (fire)                        alm_en_q <= 1'b0;
      else if (wr_en && addr == A_AEN) alm_en_q <= wdata[ALM_EN_BIT];
      if (fire)         alm_sts_q <= 1'b1;
      else if (sts_clr) alm_sts_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (win)
        W_REGS: begin
          case (addr)
            A_RUN:   rdata <= {run_q, 7'b0};
            A_AEN:   rdata <= 8'(alm_en_q) << ALM_EN_BIT;
            A_ASTS:  rdata <= {7'b0, alm_sts_q};
            default: rdata <= 8'h00;
          endcase
        end
        W_STAGE: rdata <= stage_q[lane*8 +: 8];
        W_COUNT: rdata <= cnt_q[lane*8 +: 8];
        default: rdata <= alm_q[lane*8 +: 8];
      endcase
    end
  end
endmodule

// File: rtl/rtc_seconds_chk.sv
`timescale 1ns/1ps
module rtc_seconds_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_i,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [7:0]  wdata,
  input logic [31:0] cnt_q,
  input logic        run_q,
  input logic        alm_en_q,
  input logic        alm_sts_q,
  input logic        alarm_irq
);
  logic ld;
  assign ld = wr_en && addr == 4'h4;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_q && !ld) |=> cnt_q == $past(cnt_q) + 32'd1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!tick_i || !run_q) && !ld) |=> $stable(cnt_q));

  p_load_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q[7:0] == $past(wdata));

  p_fire_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> !alm_en_q);

  p_fire_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(tick_i) && $past(alm_en_q));

  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_sts_q && !(wr_en && addr == 4'h2 && !wdata[0])) |=> alm_sts_q);
endmodule

bind rtc_seconds rtc_seconds_chk u_chk (.*);

// File: tb/sim_rtc_seconds.sv
`timescale 1ns/1ps
module sim_rtc_seconds;
  localparam int AEB = 1;
  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic alarm_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_cnt = 0, m_stage = 0, m_alm = 0;
  bit m_run = 0, m_en = 0, m_sts = 0;

  always #4 clk = ~clk;

  rtc_seconds #(.ALM_EN_BIT(AEB)) u0 (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(logic [3:0] a);
    case (a[3:2])
      2'd0: return (a == 4'h0) ? {m_run, 7'b0} :
                   (a == 4'h1) ? (8'(m_en) << AEB) :
                   (a == 4'h2) ? {7'b0, m_sts} : 8'h00;
      2'd1: return m_stage[a[1:0]*8 +: 8];
      2'd2: return m_cnt[a[1:0]*8 +: 8];
      default: return m_alm[a[1:0]*8 +: 8];
    endcase
  endfunction

  task automatic cyc(bit w, bit r, bit t, logic [3:0] a, logic [7:0] d, string req);
    logic [7:0] e;
    bit ld, fire;
    @(negedge clk);
    wr_en = w; rd_en = r; tick_i = t; addr = a; wdata = d;
    e = mread(a);
    ld = w && a == 4'h4;
    fire = t && m_run && !ld && m_en && (m_cnt + 32'd1 == m_alm);
    if (ld) m_cnt = {m_stage[31:8], d};
    else if (t && m_run) m_cnt = m_cnt + 32'd1;
    if (w && a[3:2] == 2'd1) m_stage[a[1:0]*8 +: 8] = d;
    if (w && a[3:2] == 2'd3) m_alm[a[1:0]*8 +: 8] = d;
    if (w && a == 4'h0) m_run = d[7];
    if (fire) m_en = 0; else if (w && a == 4'h1) m_en = d[AEB];
    if (fire) m_sts = 1; else if (w && a == 4'h2 && !d[0]) m_sts = 0;
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick_i = 0;
    if (r) chk(rdata == e, req, rdata, e);
    chk(alarm_irq == m_sts, "R7 irq", alarm_irq, m_sts);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, string req);
    cyc(1, 0, 0, a, d, req);
  endtask
  task automatic tk(string req);
    cyc(0, 0, 1, 4'h0, 8'h00, req);
  endtask
  task automatic rd(logic [3:0] a, string req);
    cyc(0, 1, 0, a, 8'h00, req);
  endtask
  task automatic rd_count(string req);
    for (int i = 8; i < 12; i++) rd(4'(i), req);
  endtask
  task automatic load(logic [31:0] v);
    wr(4'h7, v[31:24], "R4"); wr(4'h6, v[23:16], "R4");
    wr(4'h5, v[15:8], "R4");  wr(4'h4, v[7:0], "R4");
  endtask
  task automatic set_alarm(logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(4'(12 + i), v[i*8 +: 8], "R6");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every register zero after reset
    for (int i = 0; i < 16; i++) rd(4'(i), "R1");
    chk(alarm_irq == 1'b0, "R1 irq", alarm_irq, 0);
    // R2: counting and holding
    wr(4'h0, 8'h80, "R2");
    repeat (3) tk("R2");
    rd_count("R2");
    chk(m_cnt == 3, "R2 model", m_cnt, 3);
    wr(4'h0, 8'h00, "R2");
    repeat (2) tk("R2");
    rd(4'h8, "R2 hold");
    wr(4'h0, 8'h80, "R2");
    // R4: upper writes do not touch the count; load beats tick
    wr(4'h5, 8'h12, "R4"); wr(4'h6, 8'h34, "R4"); wr(4'h7, 8'h56, "R4");
    rd_count("R4 untouched");
    rd(4'h5, "R5 stage"); rd(4'h7, "R5 stage");
    cyc(1, 0, 1, 4'h4, 8'h9A, "R4 load+tick");
    rd_count("R4 loaded");
    chk(m_cnt == 32'h5634129A, "R4 model", m_cnt, 32'h5634129A);
    // R3: wrap
    load(32'hFFFFFFFF);
    tk("R3");
    rd_count("R3 wrap");
    chk(m_cnt == 0, "R3 model", m_cnt, 0);
    // R6 / R7: alarm fires once, disarms
    load(32'h00000100);
    set_alarm(32'h00000102);
    for (int i = 12; i < 16; i++) rd(4'(i), "R6");
    wr(4'h1, 8'h02, "R7");
    rd(4'h1, "R10 en");
    tk("R7"); tk("R7");
    chk(alarm_irq == 1'b1, "R7 fired", alarm_irq, 1);
    rd(4'h1, "R7 disarmed");
    rd(4'h2, "R7 status");
    // R8: bit0=1 keeps status, bit0=0 clears
    wr(4'h2, 8'h01, "R8 keep");
    chk(alarm_irq == 1'b1, "R8 keep", alarm_irq, 1);
    wr(4'h2, 8'hFE, "R8 clear");
    chk(alarm_irq == 1'b0, "R8 clear", alarm_irq, 0);
    // R8: fire and clear in the same cycle, fire wins
    load(32'h00000200);
    set_alarm(32'h00000201);
    wr(4'h1, 8'h02, "R8");
    cyc(1, 0, 1, 4'h2, 8'h00, "R8 collide");
    chk(alarm_irq == 1'b1, "R8 collide", alarm_irq, 1);
    wr(4'h2, 8'h00, "R8");
    // R9: disabled alarm and loaded match do not fire
    load(32'h00000300);
    set_alarm(32'h00000301);
    tk("R9 disabled");
    chk(alarm_irq == 1'b0, "R9 disabled", alarm_irq, 0);
    wr(4'h1, 8'h02, "R9");
    load(32'h00000301);
    chk(alarm_irq == 1'b0, "R9 loaded", alarm_irq, 0);
    // R10: other alarm control bits ignored
    wr(4'h1, 8'hFD, "R10");
    rd(4'h1, "R10 other bits");
    rd(4'h0, "R10 run"); rd(4'h3, "R10 unmapped");
    // random mix
    void'($urandom(32'd20250611));
    for (int n = 0; n < 3000; n++) begin
      int unsigned k;
      k = $urandom % 10;
      if (k < 4) tk("R2 rand");
      else if (k < 6) rd(4'($urandom), "R5 rand");
      else if (k < 7) cyc(1, 0, 1, 4'(4 + ($urandom % 4)), 8'($urandom), "R4 rand");
      else if (k < 8) wr(4'h0, {1'($urandom % 4 != 0), 7'($urandom)}, "R2 rand");
      else if (k < 9) begin
        set_alarm(m_cnt + 32'($urandom % 4) + 32'd1);
        wr(4'h1, 8'($urandom), "R7 rand");
      end else wr(4'($urandom), 8'($urandom), "R6 rand");
    end
    rd_count("R5 final");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule